// File: doc/BRIEF.md
# Local exclusive access monitor

This block keeps the exclusive-access reservation for one processor so that a load-exclusive / store-exclusive pair can build atomic read-modify-write sequences such as semaphores and shared counters. A load-exclusive takes a reservation: it sets a tag and stores the address. A later store-exclusive is let through to memory only if the tag is still set and its address falls in the reserved granule. In the same cycle the block returns a status word: zero means the store went through, nonzero means software must repeat the load/store pair.

Any store-exclusive drops the reservation, whether it succeeds or fails. A clear request drops it, and so does an exception-entry pulse. An interrupted pair therefore always fails and is retried, and an interrupt handler that runs its own pair cannot leave a stale reservation behind for the code it interrupted. A store to an address other than the reserved one is defined to fail, and it never reaches memory.

Top module: `excl_monitor`

## Requirements
- R1: After reset the tag is clear and the stored address is zero, so the first store-exclusive fails (st_en_o=0, st_status_o=FAIL_CODE, default 1).
- R2: A store-exclusive whose granule matches the reserved one while the tag is set raises st_en_o in the same cycle and returns st_status_o=0.
- R3: The comparison ignores address bits [GRAN_LSB-1:0] (default: bits [1:0], a 4-byte granule).
- R4: A store-exclusive to a different granule fails: st_en_o=0 and st_status_o=FAIL_CODE.
- R5: Every store-exclusive clears the tag whatever its result, so a second store with no new load fails.
- R6: A clear request (clr_i) clears the tag.
- R7: An exception-entry pulse (exc_i) clears the tag.
- R8: A newer load-exclusive replaces the reserved address. A store to the old address then fails and a store to the new one succeeds.
- R9: A store-exclusive in the same cycle as clr_i or exc_i fails.
- R10: st_en_o is high only in a cycle with st_excl_i high, and st_status_o is 0 in every cycle without a store-exclusive.
- R11: A load-exclusive in the same cycle as a store-exclusive, a clear or an exception takes no reservation. The store in that cycle is judged against the old reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_excl_i | input | 1 | Load-exclusive request, one cycle |
| st_excl_i | input | 1 | Store-exclusive request, one cycle |
| clr_i | input | 1 | Clear-exclusive request |
| exc_i | input | 1 | Exception-entry pulse |
| addr_i | input | ADDR_W | Byte address of the load or store |
| st_en_o | output | 1 | Store enable to memory, same cycle as the store request |
| st_status_o | output | STAT_W | Store result: 0 success, FAIL_CODE failure |

## Verification
On every cycle the assertions check the following: a store enable never appears without a store request, and it never appears alongside a clear or exception; a granted store always reports status zero; the tag is down in the cycle after any clearing event; and a lone load leaves the tag set with its own address stored. The bench scenarios are needed for the history-dependent outcomes. These are a replaced reservation failing the old address, a failed store still consuming the reservation, byte offsets within a granule matching, a load dropped under a concurrent store, and a reset in mid-run discarding a live reservation.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

  // One cycle of requests seen by the monitor
  typedef struct packed {
    logic ld;
    logic st;
    logic clr;
    logic exc;
  } xreq_t;

  // Any event that drops the reservation this cycle
  function automatic logic kills_resv(xreq_t r);
    return r.st | r.clr | r.exc;
  endfunction

endpackage

// File: rtl/xmon_rst_sync.sv
module xmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/xmon_resv.sv
module xmon_resv
  import xmon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xreq_t             req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              tag_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] GMASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

  logic              tag_q, tag_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              take, kill, tag_en, addr_en;

  // next-state
  always_comb begin
    kill    = kills_resv(req_i);
    take    = req_i.ld & ~kill;
    tag_en  = kill | take;
    addr_en = take;
    tag_d   = take;
    addr_d  = addr_i;
  end

  // registers with written-out enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      if (tag_en)  tag_q  <= tag_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign tag_o  = tag_q;
  assign addr_o = addr_q;

  // R5 R6 R7
  property p_kill_drops;
    @(posedge clk) disable iff (!rst_n) (req_i.st | req_i.clr | req_i.exc) |=> !tag_q;
  endproperty
  tag_cleared_chk: assert property (p_kill_drops);

  // R8
  property p_load_takes;
    @(posedge clk) disable iff (!rst_n)
      (req_i.ld && !req_i.st && !req_i.clr && !req_i.exc)
      |=> (tag_q && ((addr_q & GMASK) == ($past(addr_i) & GMASK)));
  endproperty
  load_reserves_chk: assert property (p_load_takes);

  // R11
  property p_blocked_load;
    @(posedge clk) disable iff (!rst_n)
      (req_i.ld && (req_i.st || req_i.clr || req_i.exc)) |=> $stable(addr_q);
  endproperty
  blocked_load_chk: assert property (p_blocked_load);

endmodule

// File: rtl/xmon_judge.sv
module xmon_judge
  import xmon_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                GRAN_LSB  = 2,
  parameter int                STAT_W    = 32,
  parameter logic [STAT_W-1:0] FAIL_CODE = STAT_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xreq_t             req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tag_i,
  input  logic [ADDR_W-1:0] resv_addr_i,
  output logic              st_en_o,
  output logic [STAT_W-1:0] status_o
);

  localparam logic [ADDR_W-1:0] GMASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] diff;
  logic              same_gran, blocked, grant;

  always_comb begin
    diff      = (addr_i ^ resv_addr_i) & GMASK;
    same_gran = (diff == '0);
    blocked   = req_i.clr | req_i.exc;
    grant     = req_i.st & tag_i & same_gran & ~blocked;
    st_en_o   = grant;
    if (!req_i.st)  status_o = '0;
    else if (grant) status_o = '0;
    else            status_o = FAIL_CODE;
  end

  // R10
  property p_en_needs_st;
    @(posedge clk) disable iff (!rst_n) st_en_o |-> req_i.st;
  endproperty
  en_needs_store_chk: assert property (p_en_needs_st);

  // R9
  property p_blocked_fails;
    @(posedge clk) disable iff (!rst_n) (req_i.st && (req_i.clr || req_i.exc)) |-> !st_en_o;
  endproperty
  blocked_store_chk: assert property (p_blocked_fails);

  // R2
  property p_grant_ok;
    @(posedge clk) disable iff (!rst_n) st_en_o |-> (status_o == '0);
  endproperty
  grant_status_chk: assert property (p_grant_ok);

  // R10
  property p_idle_status;
    @(posedge clk) disable iff (!rst_n) !req_i.st |-> (status_o == '0);
  endproperty
  idle_status_chk: assert property (p_idle_status);

  // R4 R1
  property p_no_tag_fails;
    @(posedge clk) disable iff (!rst_n) (req_i.st && !tag_i) |-> (!st_en_o && status_o != '0);
  endproperty
  untagged_fail_chk: assert property (p_no_tag_fails);

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import xmon_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                GRAN_LSB  = 2,
  parameter int                STAT_W    = 32,
  parameter logic [STAT_W-1:0] FAIL_CODE = STAT_W'(1),
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_excl_i,
  input  logic              st_excl_i,
  input  logic              clr_i,
  input  logic              exc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              st_en_o,
  output logic [STAT_W-1:0] st_status_o
);

  logic              rst_n_int;
  xreq_t             req;
  logic              tag;
  logic [ADDR_W-1:0] resv_addr;

  always_comb begin
    req.ld  = ld_excl_i;
    req.st  = st_excl_i;
    req.clr = clr_i;
    req.exc = exc_i;
  end

  xmon_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  xmon_resv #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_resv (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .req_i  (req),
    .addr_i (addr_i),
    .tag_o  (tag),
    .addr_o (resv_addr)
  );

  xmon_judge #(
    .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .STAT_W(STAT_W), .FAIL_CODE(FAIL_CODE)
  ) u_judge (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_i       (req),
    .addr_i      (addr_i),
    .tag_i       (tag),
    .resv_addr_i (resv_addr),
    .st_en_o     (st_en_o),
    .status_o    (st_status_o)
  );

endmodule

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;

  localparam logic [31:0] FAILV = 32'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0, st = 1'b0, clr = 1'b0, exc = 1'b0;
  logic [31:0] addr = '0;
  logic        st_en;
  logic [31:0] status;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  bit          m_tag = 0;
  logic [31:0] m_addr = '0;

  always #2.5 clk = ~clk;

  excl_monitor dut (
    .clk(clk), .rst_n(rst_n), .ld_excl_i(ld), .st_excl_i(st), .clr_i(clr),
    .exc_i(exc), .addr_i(addr), .st_en_o(st_en), .st_status_o(status)
  );

  function automatic bit exp_grant(bit t, logic [31:0] ra, bit s, bit c, bit e, logic [31:0] a);
    return t && s && !c && !e && (ra[31:2] == a[31:2]);
  endfunction

  function automatic logic [31:0] exp_status(bit s, bit g);
    return (s && !g) ? FAILV : 32'd0;
  endfunction

  task automatic step(input bit l, input bit s, input bit c, input bit e,
                      input logic [31:0] a, input string rq);
    bit g;
    logic [31:0] es;
    @(negedge clk);
    ld = l; st = s; clr = c; exc = e; addr = a;
    #1;
    g  = exp_grant(m_tag, m_addr, s, c, e, a);
    es = exp_status(s, g);
    total++;
    if (st_en !== g || status !== es) begin
      bad++;
      $display("FAIL %s: st_en=%0b status=%0d expected st_en=%0b status=%0d",
               rq, st_en, status, g, es);
    end
    // model update at the coming edge
    if (s || c || e) m_tag = 0;
    else if (l) begin m_tag = 1; m_addr = a; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    ld = 0; st = 0; clr = 0; exc = 0;
    rst_n = 0;
    m_tag = 0; m_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    do_reset();
    // R1: store right after reset fails
    step(0,1,0,0,32'h0000_0000,"R1");
    // R2 then R5
    step(1,0,0,0,32'h0000_1000,"R2 load");
    step(0,1,0,0,32'h0000_1000,"R2");
    step(0,1,0,0,32'h0000_1000,"R5 after success");
    // R3 byte offsets
    step(1,0,0,0,32'h0000_2001,"R3 load");
    step(0,1,0,0,32'h0000_2003,"R3");
    // R4 then R5 after failure
    step(1,0,0,0,32'h0000_3000,"R4 load");
    step(0,1,0,0,32'h0000_3004,"R4");
    step(0,1,0,0,32'h0000_3000,"R5 after failure");
    // R6
    step(1,0,0,0,32'h0000_4000,"R6 load");
    step(0,0,1,0,32'h0000_0000,"R6 clear");
    step(0,1,0,0,32'h0000_4000,"R6");
    // R7
    step(1,0,0,0,32'h0000_5000,"R7 load");
    step(0,0,0,1,32'h0000_0000,"R7 exception");
    step(0,1,0,0,32'h0000_5000,"R7");
    // R8
    step(1,0,0,0,32'h0000_6000,"R8 load a");
    step(1,0,0,0,32'h0000_7000,"R8 load b");
    step(0,1,0,0,32'h0000_6000,"R8 old");
    step(1,0,0,0,32'h0000_6000,"R8 load a");
    step(1,0,0,0,32'h0000_7000,"R8 load b");
    step(0,1,0,0,32'h0000_7000,"R8 new");
    // R9
    step(1,0,0,0,32'h0000_8000,"R9 load");
    step(0,1,1,0,32'h0000_8000,"R9 clr");
    step(1,0,0,0,32'h0000_8000,"R9 load");
    step(0,1,0,1,32'h0000_8000,"R9 exc");
    // R10 idle with live reservation
    step(1,0,0,0,32'h0000_9000,"R10 load");
    step(0,0,0,0,32'h0000_9000,"R10 idle");
    step(0,1,0,0,32'h0000_9000,"R10 still held");
    // R11
    step(1,0,1,0,32'h0000_A000,"R11 load+clr");
    step(0,1,0,0,32'h0000_A000,"R11 after clr");
    step(1,0,0,0,32'h0000_B000,"R11 load");
    step(1,1,0,0,32'h0000_B000,"R11 load+store");
    step(0,1,0,0,32'h0000_B000,"R11 dropped load");
    // R1: reset in mid-run drops reservation
    step(1,0,0,0,32'h0000_C000,"R1 load");
    do_reset();
    step(0,1,0,0,32'h0000_C000,"R1 after reset");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      int op;
      a  = {26'h0, 2'($urandom_range(0,3)), 4'h0} | 32'($urandom_range(0,3));
      op = $urandom_range(0,9);
      case (op)
        0,1,2,3: step(1,0,0,0,a,"R2 R8 rand load");
        4,5,6:   step(0,1,0,0,a,"R2 R4 rand store");
        7:       step($urandom_range(0,1), 0, 1, $urandom_range(0,1), a, "R6 R7 rand clear");
        8:       step($urandom_range(0,1), 1, $urandom_range(0,1), $urandom_range(0,1), a, "R9 R11 rand mix");
        default: step(0,0,0,0,a,"R10 rand idle");
      endcase
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule